// File: doc/BRIEF.md
# Data-Space Address Generator

This block forms the effective data-memory address for every load and store of a small 8-bit core. It takes the access mode, a pointer selector, a 16-bit direct address, a 6-bit I/O-instruction address, a 6-bit displacement and the current values of the three 16-bit pointer pairs that live in the top six working registers. One clock later it presents the effective address, decodes it into the working-register, I/O or SRAM region, flags addresses beyond the populated space, and flags the low I/O registers that allow single-bit set, clear and test.

The pointer modes with pre-decrement and post-increment also produce the updated pointer value. That value is split into low and high bytes, together with the working-register index of its low byte, so the register file can write it back. Combinations that have no meaning are reported as illegal. They produce no region select and no write-back. The register file, the SRAM array and instruction decode sit outside the block.

Top module: `ds_addr_gen`

## Requirements
- R1: Mode code 0 (direct) makes the effective address equal to `directAddr`, across the full 16-bit range.
- R2: Mode code 1 (indirect) makes the effective address equal to the selected pointer. Pointer select 0 is the pair in registers 26/27, select 1 is the pair in 28/29 and select 2 is the pair in 30/31. This mode produces no write-back.
- R3: Mode code 2 (displacement) makes the effective address equal to the selected pointer plus the unsigned `disp` (0 to 63), modulo 2^16. Only pointer selects 1 and 2 are allowed in this mode.
- R4: Mode code 3 (pre-decrement) makes the effective address equal to the pointer minus one, modulo 2^16. That same value is returned for write-back.
- R5: Mode code 4 (post-increment) makes the effective address equal to the unmodified pointer. The write-back value is the pointer plus one, modulo 2^16.
- R6: Write-back carries the new pointer as `wbLo` (bits 7:0) and `wbHi` (bits 15:8). `wbLoIdx` is 26 + 2 × pointer select. `wbValid` is high only for modes 3 and 4.
- R7: Mode code 5 (I/O instruction) makes the effective address equal to `ioAddr` + 0x20.
- R8: Effective addresses 0–31 raise `selReg`, addresses 32–95 raise `selIo` and addresses 96–1119 raise `selSram`. At most one of the three is high.
- R9: Effective addresses of 1120 and above raise `outOfRange` and no region select.
- R10: `bitAccess` is high exactly when the effective address lies in 0x20–0x3F.
- R11: Any of the following is illegal: mode codes 6 and 7, pointer select 3 in modes 1–4, and pointer select 0 in mode 2. An illegal request raises `illegal` and gives an effective address of 0. It also gives no region select, no `outOfRange`, no `bitAccess` and no write-back.
- R12: All outputs are registered. A request sampled on one rising edge appears after that edge with `outValid` high. In a cycle without a request, and during reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| mode | input | 3 | Access mode code |
| ptrSel | input | 2 | Pointer pair select |
| directAddr | input | 16 | Direct-mode data address |
| ioAddr | input | 6 | I/O-instruction address |
| disp | input | 6 | Unsigned displacement |
| ptrX | input | 16 | Pointer pair in registers 26/27 |
| ptrY | input | 16 | Pointer pair in registers 28/29 |
| ptrZ | input | 16 | Pointer pair in registers 30/31 |
| outValid | output | 1 | Result valid |
| effAddr | output | 16 | Effective data address |
| selReg | output | 1 | Working-register region |
| selIo | output | 1 | I/O region |
| selSram | output | 1 | SRAM region |
| outOfRange | output | 1 | Address beyond populated space |
| bitAccess | output | 1 | Bit-addressable I/O register |
| illegal | output | 1 | Illegal mode/pointer combination |
| wbValid | output | 1 | Pointer write-back present |
| wbLoIdx | output | 5 | Register index of write-back low byte |
| wbLo | output | 8 | Write-back low byte |
| wbHi | output | 8 | Write-back high byte |

## Verification
The bench builds the block with its default sizes: 32 working registers, 64 I/O registers, 1024 SRAM bytes and 16-bit pointers. It sweeps every direct address from 0 through 1200, which crosses each region boundary. It also sweeps every I/O-instruction address and every displacement on both legal pointers. Pointer values near 0 and 0xFFFF exercise the wrap of pre-decrement, post-increment and displacement. Every illegal combination is applied as well, so each decode and legality path is reached.

// File: rtl/ds_addr_gen_pkg.sv
package ds_addr_gen_pkg;

  typedef enum logic [2:0] {
    MODE_DIRECT  = 3'd0,
    MODE_IND     = 3'd1,
    MODE_DISP    = 3'd2,
    MODE_PREDEC  = 3'd3,
    MODE_POSTINC = 3'd4,
    MODE_IOINSN  = 3'd5
  } agMode_e;

  typedef struct packed {
    logic fire;
    logic illegal;
    logic useDirect;
    logic useIo;
    logic usePtr;
    logic addDisp;
    logic preDec;
    logic postInc;
  } agStrobe_t;

endpackage

// File: rtl/ds_addr_gen_ctrl.sv
module ds_addr_gen_ctrl
  import ds_addr_gen_pkg::*;
(
  input  logic       reqValid,
  input  logic [2:0] mode,
  input  logic [1:0] ptrSel,
  output agStrobe_t  strobe
);

  logic ptrBad;
  logic dispBad;

  assign ptrBad  = (ptrSel == 2'd3);
  assign dispBad = (ptrSel == 2'd0) || ptrBad;

  always_comb begin
    strobe      = '0;
    strobe.fire = reqValid;
    if (reqValid) begin
      unique case (mode)
        MODE_DIRECT:  strobe.useDirect = 1'b1;
        MODE_IOINSN:  strobe.useIo     = 1'b1;
        MODE_IND: begin
          strobe.illegal = ptrBad;
          strobe.usePtr  = !ptrBad;
        end
        MODE_DISP: begin
          strobe.illegal = dispBad;
          strobe.usePtr  = !dispBad;
          strobe.addDisp = !dispBad;
        end
        MODE_PREDEC: begin
          strobe.illegal = ptrBad;
          strobe.usePtr  = !ptrBad;
          strobe.preDec  = !ptrBad;
        end
        MODE_POSTINC: begin
          strobe.illegal = ptrBad;
          strobe.usePtr  = !ptrBad;
          strobe.postInc = !ptrBad;
        end
        default: strobe.illegal = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/ds_addr_gen_dp.sv
module ds_addr_gen_dp
  import ds_addr_gen_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int IO_ADDR_W   = 6,
  parameter int DISP_W      = 6,
  parameter int REG_COUNT   = 32,
  parameter int IO_COUNT    = 64,
  parameter int SRAM_BYTES  = 1024,
  parameter int BIT_IO_SPAN = 32,
  parameter int PTR_BASE    = 26,
  parameter int NUM_PTR     = 3,
  parameter int REG_IDX_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  agStrobe_t            strobe,
  input  logic [1:0]           ptrSel,
  input  logic [ADDR_W-1:0]    directAddr,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  input  logic [DISP_W-1:0]    disp,
  input  logic [ADDR_W-1:0]    ptrBank [NUM_PTR],
  output logic                 outValid,
  output logic [ADDR_W-1:0]    effAddr,
  output logic                 selReg,
  output logic                 selIo,
  output logic                 selSram,
  output logic                 outOfRange,
  output logic                 bitAccess,
  output logic                 illegal,
  output logic                 wbValid,
  output logic [REG_IDX_W-1:0] wbLoIdx,
  output logic [7:0]           wbLo,
  output logic [7:0]           wbHi
);

  localparam int IO_BASE   = REG_COUNT;
  localparam int SRAM_BASE = REG_COUNT + IO_COUNT;
  localparam int SPACE_TOP = SRAM_BASE + SRAM_BYTES;
  localparam int BIT_TOP   = IO_BASE + BIT_IO_SPAN;

  logic [ADDR_W-1:0] ptrVal;
  logic [ADDR_W-1:0] ptrDec;
  logic [ADDR_W-1:0] ptrInc;
  logic [ADDR_W-1:0] addrNext;
  logic [ADDR_W-1:0] wbNext;
  logic              inReg, inIo, inSram, inOor, inBit;

  always_comb begin
    ptrVal = '0;
    for (int i = 0; i < NUM_PTR; i++) begin
      if (int'(ptrSel) == i) ptrVal = ptrBank[i];
    end
  end

  assign ptrDec = ptrVal - ADDR_W'(1);
  assign ptrInc = ptrVal + ADDR_W'(1);

  always_comb begin
    addrNext = '0;
    if (strobe.useDirect)    addrNext = directAddr;
    else if (strobe.useIo)   addrNext = ADDR_W'(ioAddr) + ADDR_W'(IO_BASE);
    else if (strobe.addDisp) addrNext = ptrVal + ADDR_W'(disp);
    else if (strobe.preDec)  addrNext = ptrDec;
    else if (strobe.usePtr)  addrNext = ptrVal;
  end

  assign wbNext = strobe.preDec ? ptrDec : ptrInc;

  always_comb begin
    inReg  = 1'b0;
    inIo   = 1'b0;
    inSram = 1'b0;
    inOor  = 1'b0;
    if (strobe.fire && !strobe.illegal) begin
      if (addrNext < ADDR_W'(IO_BASE))        inReg  = 1'b1;
      else if (addrNext < ADDR_W'(SRAM_BASE)) inIo   = 1'b1;
      else if (addrNext < ADDR_W'(SPACE_TOP)) inSram = 1'b1;
      else                                    inOor  = 1'b1;
    end
  end

  assign inBit = inIo && (addrNext < ADDR_W'(BIT_TOP));

  always_ff @(posedge clk) begin
    if (!rst_n || !strobe.fire) begin
      outValid   <= 1'b0;
      effAddr    <= '0;
      selReg     <= 1'b0;
      selIo      <= 1'b0;
      selSram    <= 1'b0;
      outOfRange <= 1'b0;
      bitAccess  <= 1'b0;
      illegal    <= 1'b0;
      wbValid    <= 1'b0;
      wbLoIdx    <= '0;
      wbLo       <= '0;
      wbHi       <= '0;
    end else begin
      outValid   <= 1'b1;
      effAddr    <= addrNext;
      selReg     <= inReg;
      selIo      <= inIo;
      selSram    <= inSram;
      outOfRange <= inOor;
      bitAccess  <= inBit;
      illegal    <= strobe.illegal;
      wbValid    <= strobe.preDec || strobe.postInc;
      if (strobe.preDec || strobe.postInc) begin
        wbLoIdx <= REG_IDX_W'(PTR_BASE) + REG_IDX_W'({ptrSel, 1'b0});
        wbLo    <= wbNext[7:0];
        wbHi    <= wbNext[15:8];
      end else begin
        wbLoIdx <= '0;
        wbLo    <= '0;
        wbHi    <= '0;
      end
    end
  end

  // R8
  region_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({selReg, selIo, selSram, outOfRange}));

  // R9
  oor_noselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outOfRange |-> (!selReg && !selIo && !selSram && outValid));

  // R10
  bit_in_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bitAccess |-> (selIo && effAddr < ADDR_W'(BIT_TOP)));

  // R11
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (!wbValid && !selReg && !selIo && !selSram && !outOfRange));

  // R12
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.fire |=> outValid);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> (!wbValid && !illegal && effAddr == '0));

  // R6
  wb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> (wbLoIdx[0] == 1'b0 && wbLoIdx >= REG_IDX_W'(PTR_BASE)));

endmodule

// File: rtl/ds_addr_gen.sv
module ds_addr_gen
  import ds_addr_gen_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int IO_ADDR_W   = 6,
  parameter int DISP_W      = 6,
  parameter int REG_COUNT   = 32,
  parameter int IO_COUNT    = 64,
  parameter int SRAM_BYTES  = 1024,
  parameter int BIT_IO_SPAN = 32,
  parameter int PTR_BASE    = 26,
  parameter int REG_IDX_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reqValid,
  input  logic [2:0]           mode,
  input  logic [1:0]           ptrSel,
  input  logic [ADDR_W-1:0]    directAddr,
  input  logic [IO_ADDR_W-1:0] ioAddr,
  input  logic [DISP_W-1:0]    disp,
  input  logic [ADDR_W-1:0]    ptrX,
  input  logic [ADDR_W-1:0]    ptrY,
  input  logic [ADDR_W-1:0]    ptrZ,
  output logic                 outValid,
  output logic [ADDR_W-1:0]    effAddr,
  output logic                 selReg,
  output logic                 selIo,
  output logic                 selSram,
  output logic                 outOfRange,
  output logic                 bitAccess,
  output logic                 illegal,
  output logic                 wbValid,
  output logic [REG_IDX_W-1:0] wbLoIdx,
  output logic [7:0]           wbLo,
  output logic [7:0]           wbHi
);

  localparam int NUM_PTR = 3;

  agStrobe_t         strobe;
  logic [ADDR_W-1:0] ptrBank [NUM_PTR];

  assign ptrBank[0] = ptrX;
  assign ptrBank[1] = ptrY;
  assign ptrBank[2] = ptrZ;

  ds_addr_gen_ctrl ctrl_i (
    .reqValid (reqValid),
    .mode     (mode),
    .ptrSel   (ptrSel),
    .strobe   (strobe)
  );

  ds_addr_gen_dp #(
    .ADDR_W      (ADDR_W),
    .IO_ADDR_W   (IO_ADDR_W),
    .DISP_W      (DISP_W),
    .REG_COUNT   (REG_COUNT),
    .IO_COUNT    (IO_COUNT),
    .SRAM_BYTES  (SRAM_BYTES),
    .BIT_IO_SPAN (BIT_IO_SPAN),
    .PTR_BASE    (PTR_BASE),
    .NUM_PTR     (NUM_PTR),
    .REG_IDX_W   (REG_IDX_W)
  ) dp_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .ptrSel     (ptrSel),
    .directAddr (directAddr),
    .ioAddr     (ioAddr),
    .disp       (disp),
    .ptrBank    (ptrBank),
    .outValid   (outValid),
    .effAddr    (effAddr),
    .selReg     (selReg),
    .selIo      (selIo),
    .selSram    (selSram),
    .outOfRange (outOfRange),
    .bitAccess  (bitAccess),
    .illegal    (illegal),
    .wbValid    (wbValid),
    .wbLoIdx    (wbLoIdx),
    .wbLo       (wbLo),
    .wbHi       (wbHi)
  );

endmodule

// File: tb/ds_addr_gen_tb_top.sv
module ds_addr_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptrSel = '0;
  logic [15:0] directAddr = '0;
  logic [5:0]  ioAddr = '0;
  logic [5:0]  disp = '0;
  logic [15:0] ptrX = '0, ptrY = '0, ptrZ = '0;
  logic        outValid, selReg, selIo, selSram, outOfRange, bitAccess, illegal, wbValid;
  logic [15:0] effAddr;
  logic [4:0]  wbLoIdx;
  logic [7:0]  wbLo, wbHi;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ds_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .mode(mode), .ptrSel(ptrSel),
    .directAddr(directAddr), .ioAddr(ioAddr), .disp(disp),
    .ptrX(ptrX), .ptrY(ptrY), .ptrZ(ptrZ),
    .outValid(outValid), .effAddr(effAddr), .selReg(selReg), .selIo(selIo),
    .selSram(selSram), .outOfRange(outOfRange), .bitAccess(bitAccess),
    .illegal(illegal), .wbValid(wbValid), .wbLoIdx(wbLoIdx), .wbLo(wbLo), .wbHi(wbHi)
  );

  // packed view: valid, addr16, reg, io, sram, oor, bit, ill, wbv, idx5, lo8, hi8
  function automatic logic [52:0] actual();
    return {outValid, effAddr, selReg, selIo, selSram, outOfRange, bitAccess,
            illegal, wbValid, wbLoIdx, wbLo, wbHi};
  endfunction

  function automatic logic [52:0] model(input logic [2:0] m, input logic [1:0] ps,
                                        input logic [15:0] da, input logic [5:0] ia,
                                        input logic [5:0] d, input logic [15:0] px,
                                        input logic [15:0] py, input logic [15:0] pz);
    logic [15:0] p, a, w;
    logic ill, wv, r, io, s, o, b;
    p = (ps == 2'd0) ? px : (ps == 2'd1) ? py : pz;
    ill = 1'b0; wv = 1'b0; a = '0; w = '0;
    case (m)
      3'd0: a = da;
      3'd5: a = {10'd0, ia} + 16'h20;
      3'd1: begin ill = (ps == 2'd3); a = p; end
      3'd2: begin ill = (ps == 2'd3) || (ps == 2'd0); a = p + {10'd0, d}; end
      3'd3: begin ill = (ps == 2'd3); a = p - 16'd1; w = a; wv = 1'b1; end
      3'd4: begin ill = (ps == 2'd3); a = p; w = p + 16'd1; wv = 1'b1; end
      default: ill = 1'b1;
    endcase
    if (ill) begin a = '0; w = '0; wv = 1'b0; end
    r  = !ill && a < 16'd32;
    io = !ill && a >= 16'd32 && a < 16'd96;
    s  = !ill && a >= 16'd96 && a < 16'd1120;
    o  = !ill && a >= 16'd1120;
    b  = !ill && a >= 16'h20 && a <= 16'h3F;
    return {1'b1, a, r, io, s, o, b, ill, wv,
            wv ? 5'(26 + 2 * ps) : 5'd0, w[7:0], w[15:8]};
  endfunction

  task automatic check(input string tag, input logic [52:0] exp);
    checks++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, actual(), exp);
    end
  endtask

  task automatic issue(input string tag, input logic [2:0] m, input logic [1:0] ps,
                       input logic [15:0] da, input logic [5:0] ia, input logic [5:0] d,
                       input logic [15:0] px, input logic [15:0] py, input logic [15:0] pz);
    @(negedge clk);
    reqValid = 1'b1; mode = m; ptrSel = ps; directAddr = da; ioAddr = ia; disp = d;
    ptrX = px; ptrY = py; ptrZ = pz;
    @(negedge clk);
    reqValid = 1'b0;
    check(tag, model(m, ps, da, ia, d, px, py, pz));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    // R12: reset state, even with a request held
    reqValid = 1'b1; mode = 3'd0; directAddr = 16'h0040;
    repeat (3) @(negedge clk);
    check("R12 reset", 53'd0);
    reqValid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 idle", 53'd0);

    // R1 R8 R9 R10: direct sweep across all region boundaries
    for (int a = 0; a <= 1200; a++)
      issue("R1/R8/R9/R10 direct", 3'd0, 2'd0, 16'(a), 6'd0, 6'd0, 0, 0, 0);
    issue("R1 R9 direct top", 3'd0, 2'd2, 16'hFFFF, 6'd0, 6'd0, 0, 0, 0);

    // R7 R10: every I/O-instruction address
    for (int i = 0; i < 64; i++)
      issue("R7 io map", 3'd5, 2'd0, 16'h1234, 6'(i), 6'd0, 0, 0, 0);

    // R2: each pointer, no write-back
    for (int s = 0; s < 3; s++)
      issue("R2 indirect", 3'd1, 2'(s), 0, 0, 0, 16'h0010, 16'h0050, 16'h0200);

    // R3: every displacement on Y and Z, including wrap
    for (int d = 0; d < 64; d++) begin
      issue("R3 disp Y", 3'd2, 2'd1, 0, 0, 6'(d), 16'h0005, 16'h0041, 16'h0000);
      issue("R3 disp Z", 3'd2, 2'd2, 0, 0, 6'(d), 16'h0000, 16'h0000, 16'hFFE0);
    end

    // R4 R5 R6: pre-decrement and post-increment with wrap on every pointer
    for (int s = 0; s < 3; s++) begin
      issue("R4 predec wrap", 3'd3, 2'(s), 0, 0, 0, 16'h0000, 16'h0000, 16'h0000);
      issue("R4 predec", 3'd3, 2'(s), 0, 0, 0, 16'h0460, 16'h0100, 16'h0021);
      issue("R5 postinc wrap", 3'd4, 2'(s), 0, 0, 0, 16'hFFFF, 16'hFFFF, 16'hFFFF);
      issue("R5 R6 postinc", 3'd4, 2'(s), 0, 0, 0, 16'h00FF, 16'h045F, 16'h0060);
    end

    // R11: illegal combinations
    issue("R11 disp X", 3'd2, 2'd0, 0, 0, 6'd3, 16'h0070, 0, 0);
    for (int m = 1; m <= 4; m++)
      issue("R11 ptr3", 3'(m), 2'd3, 0, 0, 0, 16'h0070, 16'h0070, 16'h0070);
    issue("R11 mode6", 3'd6, 2'd1, 16'h0040, 0, 0, 0, 0, 0);
    issue("R11 mode7", 3'd7, 2'd2, 16'h0040, 0, 0, 0, 0, 0);

    // R12: output returns to zero after the request
    @(negedge clk);
    check("R12 drop", 53'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule